// File: doc/BRIEF.md
# Banked Video Memory Access Arbiter

This block sits between three requesters and three independent video memory banks, each sixteen bits wide: a large 64 KiB bank and two small 16 KiB banks. The requesters are a processor port, which may read and write, and two read-only display ports: one for background fetches and one for sprite fetches. The block runs its own dot and line counters. These tell it whether the current line is on screen or in vertical blank. From them it decides, cycle by cycle, which requester drives each bank.

The video mode decides which display port owns the middle bank. In the tile modes (0, 1, 2) the sprite port owns both small banks. In the bitmap modes (3, 4, 5 and above) the background port takes the first small bank as well, and sprites keep only the last one. During blanking the processor gets every cycle. On a visible line, background fetches come first. The processor waits whenever a background fetch holds its bank, and it wins over a sprite fetch on the same bank.

Each line carries a budget of sprite slots: the line length minus the background share of four slots per visible pixel. Sprite grants draw it down, and so do processor accesses made on a visible line. Once the budget is empty, sprite requests on that line are refused and a sticky dropout flag records it. Requesters see a registered grant, and read data arrives one cycle after the grant.

Top module: `vram_arbiter`

## Requirements
- R1: `hpos` counts 0 to LINE_DOTS-1 (default 1232) and wraps to 0. At each wrap `vpos` advances and wraps after TOTAL_LINES-1. `vblank` is 1 exactly when `vpos` >= VIS_LINES.
- R2: A 16-bit word offset selects the bank. Bit 15 = 0 selects the 64 KiB bank (bank 0, word index = offset bits 14..0). Bit 15 = 1 with bit 13 = 0 selects bank 1. Bit 15 = 1 with bit 13 = 1 selects bank 2. For banks 1 and 2 the word index is bits 12..0. Byte offsets 0x00000–0x0FFFF, 0x10000–0x13FFF and 0x14000–0x17FFF therefore land in banks 0, 1 and 2.
- R3: In modes 0–2 the background port owns bank 0 and the sprite port owns banks 1 and 2. In modes 3 and above the background port owns banks 0 and 1 and the sprite port owns bank 2. A display request to a bank its port does not own is never granted.
- R4: While `vblank` is 1, every processor request is granted and no display request is granted.
- R5: On a visible line, a background request to an owned bank is always granted. A processor request is granted unless that background grant is on the same bank. If the processor request is not granted, `cpu_wait` is 1 in the cycle after the request.
- R6: On a visible line, a sprite request to an owned bank is granted if the sprite budget is nonzero and no processor grant is on the same bank in that cycle.
- R7: The sprite budget reloads to LINE_DOTS - 4*VIS_PIX (272 by default) at reset and on the cycle where `hpos` wraps. In every other cycle it drops by one for each sprite grant and one for each processor grant on a visible line, and it stops at zero.
- R8: A sprite request on a visible line to an owned bank that meets an empty budget sets `spr_dropout`. The flag then stays 1 until reset.
- R9: A grant is high in the cycle after the request it answers. For a read, `*_rvalid` is high one cycle after the grant, and `*_rdata` then carries the word read from the routed bank. A processor write reaches the bank's write port in the same cycle as its grant.
- R10: Each bank serves at most one access per cycle. The number of asserted `bank_en` bits equals the number of grants.
- R11: While `rst_n` is 0, `hpos`, `vpos`, all grants, `cpu_wait`, all `*_rvalid`, `bank_en` and `spr_dropout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock (one fetch slot per cycle) |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Video mode; 3 and above are bitmap modes |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write when 1, read when 0 |
| cpu_addr | input | 16 | Processor word offset |
| cpu_wdata | input | 16 | Processor write data |
| cpu_gnt | output | 1 | Processor request granted (one cycle after request) |
| cpu_wait | output | 1 | Processor request held off by a display fetch |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | 16 | Processor read data |
| bg_req | input | 1 | Background fetch request |
| bg_addr | input | 16 | Background fetch word offset |
| bg_gnt | output | 1 | Background fetch granted |
| bg_rvalid | output | 1 | Background read data valid |
| bg_rdata | output | 16 | Background read data |
| spr_req | input | 1 | Sprite fetch request |
| spr_addr | input | 16 | Sprite fetch word offset |
| spr_gnt | output | 1 | Sprite fetch granted |
| spr_rvalid | output | 1 | Sprite read data valid |
| spr_rdata | output | 16 | Sprite read data |
| hpos | output | 11 | Dot counter within the line |
| vpos | output | 8 | Line counter within the frame |
| vblank | output | 1 | Vertical blank in progress |
| spr_dropout | output | 1 | Sticky: a sprite fetch was refused for lack of slots |
| bank_en | output | 3 | Per-bank access strobe |
| bank_we | output | 3 | Per-bank write enable |
| bank_addr | output | 45 | Per-bank 15-bit word index, bank b at bits 15b+14..15b |
| bank_wdata | output | 48 | Per-bank write data, bank b at bits 16b+15..16b |
| bank_rdata | input | 48 | Per-bank synchronous read data, same packing |

## Verification
The request inputs are applied just after a falling edge, so the decision is made at the next rising edge. The grants, `cpu_wait`, the bank strobes, the counters and `spr_dropout` are compared at the following falling edge. Read valid and read data come one register later, so they are compared one falling edge after that, against the grant decision held from the step before. The bench model advances its own dot, line and budget state once per step, with the budget reload taking the place of the decrement on the wrap cycle. The expected budget boundary and dropout cycle are therefore exact.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

   localparam int NBANKS  = 3;
   localparam int OFS_W   = 16;
   localparam int BANK_AW = 15;

   typedef enum logic [1:0] {
      BANK_MAIN = 2'd0,
      BANK_LO   = 2'd1,
      BANK_HI   = 2'd2
   } bank_e;

   function automatic bank_e bank_of(input logic [OFS_W-1:0] w);
      if (!w[15])     return BANK_MAIN;
      else if (w[13]) return BANK_HI;
      else            return BANK_LO;
   endfunction

   function automatic logic [BANK_AW-1:0] word_index(input logic [OFS_W-1:0] w);
      if (w[15]) return {2'b00, w[12:0]};
      else       return w[14:0];
   endfunction

   function automatic logic bg_owns(input bank_e b, input logic bitmap);
      return (b == BANK_MAIN) || (b == BANK_LO && bitmap);
   endfunction

   function automatic logic spr_owns(input bank_e b, input logic bitmap);
      return (b == BANK_HI) || (b == BANK_LO && !bitmap);
   endfunction

endpackage

// File: rtl/vram_arb_timing.sv
module vram_arb_timing #(
   parameter int LINE_DOTS   = 1232,
   parameter int TOTAL_LINES = 228,
   parameter int VIS_LINES   = 160,
   localparam int HW = $clog2(LINE_DOTS),
   localparam int VW = $clog2(TOTAL_LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [HW-1:0] hpos,
   output logic [VW-1:0] vpos,
   output logic          line_end,
   output logic          active
);

   localparam logic [HW-1:0] H_LAST = HW'(LINE_DOTS - 1);
   localparam logic [VW-1:0] V_LAST = VW'(TOTAL_LINES - 1);
   localparam logic [VW-1:0] V_VIS  = VW'(VIS_LINES);

   assign line_end = (hpos == H_LAST);
   assign active   = (vpos < V_VIS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hpos <= '0;
         vpos <= '0;
      end else if (line_end) begin
         hpos <= '0;
         vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
      end else begin
         hpos <= hpos + 1'b1;
      end
   end

endmodule

// File: rtl/vram_arb_decide.sv
module vram_arb_decide
   import vram_arb_pkg::*;
(
   input  logic             active,
   input  logic             bitmap,
   input  logic             has_slot,
   input  logic             cpu_req,
   input  logic [OFS_W-1:0] cpu_addr,
   input  logic             bg_req,
   input  logic [OFS_W-1:0] bg_addr,
   input  logic             spr_req,
   input  logic [OFS_W-1:0] spr_addr,
   output bank_e            cpu_bank,
   output bank_e            bg_bank,
   output bank_e            spr_bank,
   output logic             cpu_win,
   output logic             bg_win,
   output logic             spr_win,
   output logic             spr_refuse,
   output logic             cpu_steal
);

   logic spr_ok;

   always_comb begin
      cpu_bank   = bank_of(cpu_addr);
      bg_bank    = bank_of(bg_addr);
      spr_bank   = bank_of(spr_addr);
      // background fetches have first claim on their banks
      bg_win     = active && bg_req && bg_owns(bg_bank, bitmap);
      cpu_win    = cpu_req && !(bg_win && (bg_bank == cpu_bank));
      spr_ok     = active && spr_req && spr_owns(spr_bank, bitmap);
      spr_refuse = spr_ok && !has_slot;
      spr_win    = spr_ok && has_slot && !(cpu_win && (cpu_bank == spr_bank));
      cpu_steal  = active && cpu_win;
   end

endmodule

// File: rtl/vram_arb_budget.sv
module vram_arb_budget #(
   parameter int RELOAD = 272,
   localparam int BW = $clog2(RELOAD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_end,
   input  logic spr_take,
   input  logic cpu_take,
   input  logic refuse,
   output logic has_slot,
   output logic dropout
);

   logic [BW-1:0] left;
   logic [BW-1:0] dec;

   assign dec      = BW'({1'b0, spr_take}) + BW'({1'b0, cpu_take});
   assign has_slot = (left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left    <= BW'(RELOAD);
         dropout <= 1'b0;
      end else begin
         if (line_end)        left <= BW'(RELOAD);
         else if (left > dec) left <= left - dec;
         else                 left <= '0;
         if (refuse) dropout <= 1'b1;
      end
   end

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
   import vram_arb_pkg::*;
#(
   parameter int LINE_DOTS     = 1232,
   parameter int TOTAL_LINES   = 228,
   parameter int VIS_LINES     = 160,
   parameter int VIS_PIX       = 240,
   parameter int SLOTS_PER_PIX = 4,
   parameter int DATA_W        = 16,
   localparam int HW = $clog2(LINE_DOTS),
   localparam int VW = $clog2(TOTAL_LINES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0]                mode,
   input  logic                      cpu_req,
   input  logic                      cpu_we,
   input  logic [OFS_W-1:0]          cpu_addr,
   input  logic [DATA_W-1:0]         cpu_wdata,
   output logic                      cpu_gnt,
   output logic                      cpu_wait,
   output logic                      cpu_rvalid,
   output logic [DATA_W-1:0]         cpu_rdata,
   input  logic                      bg_req,
   input  logic [OFS_W-1:0]          bg_addr,
   output logic                      bg_gnt,
   output logic                      bg_rvalid,
   output logic [DATA_W-1:0]         bg_rdata,
   input  logic                      spr_req,
   input  logic [OFS_W-1:0]          spr_addr,
   output logic                      spr_gnt,
   output logic                      spr_rvalid,
   output logic [DATA_W-1:0]         spr_rdata,
   output logic [HW-1:0]             hpos,
   output logic [VW-1:0]             vpos,
   output logic                      vblank,
   output logic                      spr_dropout,
   output logic [NBANKS-1:0]         bank_en,
   output logic [NBANKS-1:0]         bank_we,
   output logic [NBANKS*BANK_AW-1:0] bank_addr,
   output logic [NBANKS*DATA_W-1:0]  bank_wdata,
   input  logic [NBANKS*DATA_W-1:0]  bank_rdata
);

   localparam int BG_SLOTS = VIS_PIX * SLOTS_PER_PIX;
   localparam int RELOAD   = LINE_DOTS - BG_SLOTS;

   if (RELOAD < 2) begin : g_bad_line
      $error("line too short for background plus sprite slots");
   end
   if (VIS_LINES < 1 || VIS_LINES >= TOTAL_LINES) begin : g_bad_frame
      $error("visible lines must leave at least one blank line");
   end

   logic  line_end, active, has_slot;
   logic  cpu_win, bg_win, spr_win, spr_refuse, cpu_steal;
   bank_e cpu_bank, bg_bank, spr_bank;

   vram_arb_timing #(
      .LINE_DOTS  (LINE_DOTS),
      .TOTAL_LINES(TOTAL_LINES),
      .VIS_LINES  (VIS_LINES)
   ) u_timing (
      .clk     (clk),
      .rst_n   (rst_n),
      .hpos    (hpos),
      .vpos    (vpos),
      .line_end(line_end),
      .active  (active)
   );

   assign vblank = !active;

   vram_arb_decide u_decide (
      .active    (active),
      .bitmap    (mode >= 3'd3),
      .has_slot  (has_slot),
      .cpu_req   (cpu_req),
      .cpu_addr  (cpu_addr),
      .bg_req    (bg_req),
      .bg_addr   (bg_addr),
      .spr_req   (spr_req),
      .spr_addr  (spr_addr),
      .cpu_bank  (cpu_bank),
      .bg_bank   (bg_bank),
      .spr_bank  (spr_bank),
      .cpu_win   (cpu_win),
      .bg_win    (bg_win),
      .spr_win   (spr_win),
      .spr_refuse(spr_refuse),
      .cpu_steal (cpu_steal)
   );

   vram_arb_budget #(.RELOAD(RELOAD)) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_end(line_end),
      .spr_take(spr_win),
      .cpu_take(cpu_steal),
      .refuse  (spr_refuse),
      .has_slot(has_slot),
      .dropout (spr_dropout)
   );

   // grant stage and read-return stage
   bank_e cpu_tag1, bg_tag1, spr_tag1, cpu_tag2, bg_tag2, spr_tag2;
   logic  cpu_rd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_gnt    <= 1'b0;
         bg_gnt     <= 1'b0;
         spr_gnt    <= 1'b0;
         cpu_wait   <= 1'b0;
         cpu_rd1    <= 1'b0;
         cpu_rvalid <= 1'b0;
         bg_rvalid  <= 1'b0;
         spr_rvalid <= 1'b0;
         cpu_tag1   <= BANK_MAIN;
         bg_tag1    <= BANK_MAIN;
         spr_tag1   <= BANK_MAIN;
         cpu_tag2   <= BANK_MAIN;
         bg_tag2    <= BANK_MAIN;
         spr_tag2   <= BANK_MAIN;
      end else begin
         cpu_gnt    <= cpu_win;
         bg_gnt     <= bg_win;
         spr_gnt    <= spr_win;
         cpu_wait   <= cpu_req && !cpu_win;
         cpu_rd1    <= cpu_win && !cpu_we;
         cpu_rvalid <= cpu_rd1;
         bg_rvalid  <= bg_gnt;
         spr_rvalid <= spr_gnt;
         cpu_tag1   <= cpu_bank;
         bg_tag1    <= bg_bank;
         spr_tag1   <= spr_bank;
         cpu_tag2   <= cpu_tag1;
         bg_tag2    <= bg_tag1;
         spr_tag2   <= spr_tag1;
      end
   end

   assign cpu_rdata = bank_rdata[int'(cpu_tag2)*DATA_W +: DATA_W];
   assign bg_rdata  = bank_rdata[int'(bg_tag2)*DATA_W +: DATA_W];
   assign spr_rdata = bank_rdata[int'(spr_tag2)*DATA_W +: DATA_W];

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic               hit_bg, hit_cpu, hit_spr;
      logic               en_q, we_q;
      logic [BANK_AW-1:0] addr_q;
      logic [DATA_W-1:0]  wd_q;

      assign hit_bg  = bg_win  && (bg_bank  == bank_e'(b));
      assign hit_cpu = cpu_win && (cpu_bank == bank_e'(b));
      assign hit_spr = spr_win && (spr_bank == bank_e'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            we_q   <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
         end else begin
            en_q <= hit_bg || hit_cpu || hit_spr;
            we_q <= hit_cpu && cpu_we;
            if (hit_bg)       addr_q <= word_index(bg_addr);
            else if (hit_cpu) addr_q <= word_index(cpu_addr);
            else if (hit_spr) addr_q <= word_index(spr_addr);
            if (hit_cpu) wd_q <= cpu_wdata;
         end
      end

      assign bank_en[b]                        = en_q;
      assign bank_we[b]                        = we_q;
      assign bank_addr[b*BANK_AW +: BANK_AW]   = addr_q;
      assign bank_wdata[b*DATA_W +: DATA_W]    = wd_q;
   end

endmodule

// File: rtl/vram_arbiter_chk.sv
module vram_arbiter_chk #(
   parameter int LINE_DOTS = 1232,
   parameter int HW        = 11,
   parameter int NB        = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    mode,
   input logic [15:0]   bg_addr,
   input logic [15:0]   spr_addr,
   input logic          cpu_req,
   input logic          cpu_gnt,
   input logic          cpu_wait,
   input logic          bg_gnt,
   input logic          spr_gnt,
   input logic          bg_rvalid,
   input logic          spr_rvalid,
   input logic          vblank,
   input logic          spr_dropout,
   input logic [HW-1:0] hpos,
   input logic [NB-1:0] bank_en
);

   assert_hpos_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (hpos == HW'(LINE_DOTS - 1)) |=> (hpos == '0));

   assert_hpos_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (hpos != HW'(LINE_DOTS - 1)) |=> (hpos == $past(hpos) + 1'b1));

   assert_bg_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bg_gnt |-> !($past(mode) < 3'd3 && $past(bg_addr[15]) && !$past(bg_addr[13])));

   assert_spr_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      spr_gnt |-> ($past(spr_addr[15]) &&
                   !($past(mode) >= 3'd3 && !$past(spr_addr[13]))));

   assert_cpu_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank && cpu_req) |=> cpu_gnt);

   assert_no_fetch_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vblank |=> (!bg_gnt && !spr_gnt));

   assert_wait_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> (!cpu_gnt && !$past(vblank) && $past(cpu_req)));

   assert_dropout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      spr_dropout |=> spr_dropout);

   assert_bg_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bg_gnt |=> bg_rvalid);

   assert_spr_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      spr_gnt |=> spr_rvalid);

   assert_one_per_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cpu_gnt, bg_gnt, spr_gnt}) == $countones(bank_en));

endmodule

bind vram_arbiter vram_arbiter_chk #(
   .LINE_DOTS(LINE_DOTS),
   .HW       (HW),
   .NB       (3)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .bg_addr    (bg_addr),
   .spr_addr   (spr_addr),
   .cpu_req    (cpu_req),
   .cpu_gnt    (cpu_gnt),
   .cpu_wait   (cpu_wait),
   .bg_gnt     (bg_gnt),
   .spr_gnt    (spr_gnt),
   .bg_rvalid  (bg_rvalid),
   .spr_rvalid (spr_rvalid),
   .vblank     (vblank),
   .spr_dropout(spr_dropout),
   .hpos       (hpos),
   .bank_en    (bank_en)
);

// File: tb/tb_vram_arbiter.sv
module tb_vram_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int DOTS   = 1232;
   localparam int TOT    = 5;
   localparam int VIS    = 3;
   localparam int RELOAD = DOTS - 240 * 4;
   localparam int HW = $clog2(DOTS);
   localparam int VW = $clog2(TOT);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0]  mode = '0;
   logic        cpu_req = 0, cpu_we = 0, bg_req = 0, spr_req = 0;
   logic [15:0] cpu_addr = '0, cpu_wdata = '0, bg_addr = '0, spr_addr = '0;
   logic        cpu_gnt, cpu_wait, cpu_rvalid, bg_gnt, bg_rvalid, spr_gnt, spr_rvalid;
   logic [15:0] cpu_rdata, bg_rdata, spr_rdata;
   logic [HW-1:0] hpos;
   logic [VW-1:0] vpos;
   logic        vblank, spr_dropout;
   logic [2:0]  bank_en, bank_we;
   logic [44:0] bank_addr;
   logic [47:0] bank_wdata, bank_rdata;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vram_arbiter #(.LINE_DOTS(DOTS), .TOTAL_LINES(TOT), .VIS_LINES(VIS)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_gnt(cpu_gnt), .cpu_wait(cpu_wait), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .bg_req(bg_req), .bg_addr(bg_addr), .bg_gnt(bg_gnt), .bg_rvalid(bg_rvalid), .bg_rdata(bg_rdata),
      .spr_req(spr_req), .spr_addr(spr_addr), .spr_gnt(spr_gnt), .spr_rvalid(spr_rvalid),
      .spr_rdata(spr_rdata), .hpos(hpos), .vpos(vpos), .vblank(vblank), .spr_dropout(spr_dropout),
      .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
      .bank_rdata(bank_rdata)
   );

   // synchronous bank models, aliased to 256 words each
   logic [15:0] mem [3][256];
   logic [15:0] rd_q [3];
   always_ff @(posedge clk) begin
      for (int b = 0; b < 3; b++) begin
         if (bank_en[b]) begin
            if (bank_we[b]) mem[b][bank_addr[b*15 +: 8]] <= bank_wdata[b*16 +: 16];
            else            rd_q[b] <= mem[b][bank_addr[b*15 +: 8]];
         end
      end
   end
   assign bank_rdata = {rd_q[2], rd_q[1], rd_q[0]};

   int checks = 0, fails = 0;
   bit done = 0;

   // bench reference state
   int mdot, mline, mbud;
   bit mdrop;
   logic [15:0] shadow [3][256];
   bit p_cpu_rv, p_bg_rv, p_spr_rv;
   logic [15:0] p_cpu_d, p_bg_d, p_spr_d;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int bank_of(input logic [15:0] w);
      if (!w[15]) return 0;
      return w[13] ? 2 : 1;
   endfunction

   function automatic logic [15:0] pick_addr(input int b);
      logic [15:0] r = 16'($urandom);
      if (b == 0) return {1'b0, r[14:0]};
      if (b == 1) return {2'b10, r[13], 1'b0, r[11:0]};
      return {2'b10, r[13], 1'b1, r[11:0]};
   endfunction

   task automatic model_reset();
      mdot = 0; mline = 0; mbud = RELOAD; mdrop = 0;
      p_cpu_rv = 0; p_bg_rv = 0; p_spr_rv = 0;
   endtask

   task automatic step(input bit cr, input bit we, input logic [15:0] ca, input logic [15:0] wd,
                       input bit br, input logic [15:0] ba, input bit sr, input logic [15:0] sa,
                       input logic [2:0] md);
      bit act, bmp, bgo, spo, ebg, ecpu, espr, spok, eref, ewait;
      int cb, bb, sb, dec, nwin;
      logic [15:0] d_cpu, d_bg, d_spr;
      mode = md; cpu_req = cr; cpu_we = we; cpu_addr = ca; cpu_wdata = wd;
      bg_req = br; bg_addr = ba; spr_req = sr; spr_addr = sa;
      act = (mline < VIS);
      bmp = (md >= 3);
      cb = bank_of(ca); bb = bank_of(ba); sb = bank_of(sa);
      bgo  = (bb == 0) || (bb == 1 && bmp);
      spo  = (sb == 2) || (sb == 1 && !bmp);
      ebg  = act && br && bgo;
      ecpu = cr && !(ebg && bb == cb);
      spok = act && sr && spo;
      eref = spok && (mbud == 0);
      espr = spok && (mbud != 0) && !(ecpu && cb == sb);
      ewait = cr && !ecpu;
      nwin = int'(ebg) + int'(ecpu) + int'(espr);
      d_cpu = shadow[cb][ca[7:0]];
      d_bg  = shadow[bb][ba[7:0]];
      d_spr = shadow[sb][sa[7:0]];
      if (ecpu && we) shadow[cb][ca[7:0]] = wd;
      if (mdot == DOTS - 1) begin
         mdot = 0; mline = (mline + 1) % TOT; mbud = RELOAD;
      end else begin
         mdot++;
         dec = int'(espr) + int'(act && ecpu);
         mbud = (mbud > dec) ? mbud - dec : 0;
      end
      if (eref) mdrop = 1;
      @(negedge clk);
      chk("R1 hpos", 32'(hpos), 32'(mdot));
      chk("R1 vpos", 32'(vpos), 32'(mline));
      chk("R1 vblank", 32'(vblank), 32'(mline >= VIS));
      if (act) chk("R5 cpu_gnt", 32'(cpu_gnt), 32'(ecpu));
      else     chk("R4 cpu_gnt", 32'(cpu_gnt), 32'(ecpu));
      chk("R5 cpu_wait", 32'(cpu_wait), 32'(ewait));
      chk("R3 bg_gnt", 32'(bg_gnt), 32'(ebg));
      chk("R6 R7 spr_gnt", 32'(spr_gnt), 32'(espr));
      chk("R8 spr_dropout", 32'(spr_dropout), 32'(mdrop));
      chk("R10 bank_en count", 32'($countones(bank_en)), 32'(nwin));
      chk("R9 cpu_rvalid", 32'(cpu_rvalid), 32'(p_cpu_rv));
      chk("R9 bg_rvalid", 32'(bg_rvalid), 32'(p_bg_rv));
      chk("R9 spr_rvalid", 32'(spr_rvalid), 32'(p_spr_rv));
      if (p_cpu_rv) chk("R2 cpu_rdata", 32'(cpu_rdata), 32'(p_cpu_d));
      if (p_bg_rv)  chk("R2 bg_rdata", 32'(bg_rdata), 32'(p_bg_d));
      if (p_spr_rv) chk("R2 spr_rdata", 32'(spr_rdata), 32'(p_spr_d));
      p_cpu_rv = ecpu && !we; p_cpu_d = d_cpu;
      p_bg_rv  = ebg;         p_bg_d  = d_bg;
      p_spr_rv = espr;        p_spr_d = d_spr;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      cpu_req = 0; bg_req = 0; spr_req = 0;
      repeat (3) @(negedge clk);
      chk("R11 hpos", 32'(hpos), 0);
      chk("R11 vpos", 32'(vpos), 0);
      chk("R11 grants", 32'({cpu_gnt, bg_gnt, spr_gnt, cpu_wait}), 0);
      chk("R11 rvalid", 32'({cpu_rvalid, bg_rvalid, spr_rvalid}), 0);
      chk("R11 bank_en", 32'(bank_en), 0);
      chk("R11 dropout", 32'(spr_dropout), 0);
      model_reset();
      rst_n = 1;
   endtask

   task automatic random_run(input int n, input int pc, input int pb, input int ps);
      logic [2:0] md = 3'($urandom_range(0, 5));
      for (int i = 0; i < n; i++) begin
         if (i % 300 == 0) md = 3'($urandom_range(0, 5));
         step($urandom_range(0, 99) < pc, $urandom_range(0, 1) == 1,
              pick_addr($urandom_range(0, 2)), 16'($urandom),
              $urandom_range(0, 99) < pb, pick_addr($urandom_range(0, 1)),
              $urandom_range(0, 99) < ps, pick_addr($urandom_range(1, 2)), md);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int b = 0; b < 3; b++)
         for (int i = 0; i < 256; i++) begin
            mem[b][i] = '0; shadow[b][i] = '0;
         end
      do_reset();
      // directed: same-bank clash between background and processor (R5)
      step(1, 0, 16'h0010, 16'h0, 1, 16'h0020, 0, 16'h0, 3'd0);
      // directed: sprite to bank 1 in bitmap mode refused (R3), bank 2 granted (R6)
      step(0, 0, 16'h0, 16'h0, 0, 16'h0, 1, 16'h8004, 3'd3);
      step(0, 0, 16'h0, 16'h0, 0, 16'h0, 1, 16'hA004, 3'd3);
      // directed: background to bank 1 in bitmap mode granted (R3)
      step(0, 0, 16'h0, 16'h0, 1, 16'h8008, 0, 16'h0, 3'd4);
      // directed: processor write then read back through bank 2 (R2, R9)
      step(1, 1, 16'hA033, 16'hBEEF, 0, 16'h0, 0, 16'h0, 3'd0);
      step(1, 0, 16'hA033, 16'h0, 0, 16'h0, 0, 16'h0, 3'd0);
      step(0, 0, 16'h0, 16'h0, 0, 16'h0, 0, 16'h0, 3'd0);
      // heavy random load: budget drains, dropout expected, vblank reached
      random_run(7000, 40, 50, 60);
      // light load after reset: budget never empties
      do_reset();
      random_run(2500, 5, 50, 10);
      // sprite-only hammering on a visible line until dropout (R7, R8)
      do_reset();
      for (int i = 0; i < RELOAD + 20; i++)
         step(0, 0, 16'h0, 16'h0, 0, 16'h0, 1, 16'hA000 + 16'(i), 3'd1);
      chk("R8 dropout after budget", 32'(spr_dropout), 1);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule